// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor Table

This block holds a direct-mapped array of 2-bit saturating counters that guess whether a conditional branch will be taken. The fetch stage presents the current PC on the lookup port and gets a taken or not-taken guess back combinationally in the same cycle. Later, once the branch has resolved, the pipeline presents the branch PC and its real outcome on the update port, and the selected counter moves one step toward that outcome on the next clock edge.

The counter is selected by PC bits just above the two alignment bits. There are no tags, so branches whose PCs share those bits share one counter. This aliasing is accepted. Because each counter has two states on each side, a single surprise outcome does not flip the guess. A loop branch therefore costs one miss per visit instead of two.

Top module: `bht_2bit`

## Requirements
- R1: After reset every counter holds 01 (weak not-taken), so every lookup predicts not-taken.
- R2: The entry is selected by PC bits [IDX_W+1:2]. PC bits [1:0] and all bits above IDX_W+1 have no effect, so two PCs that differ only there share one counter.
- R3: lk_taken equals bit 1 of the selected counter (10 and 11 predict taken, 00 and 01 predict not-taken). It is produced combinationally from lk_pc in the same cycle.
- R4: A valid update with up_taken=1 moves the counter one step up (00→01→10→11) on the next clock edge. It stays at 11 when already there.
- R5: A valid update with up_taken=0 moves the counter one step down (11→10→01→00) on the next clock edge. It stays at 00 when already there.
- R6: When up_valid is 0 no counter changes. A valid update changes only the counter it selects.
- R7: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction from before the update.
- R8: For a loop branch taken nine times and then not taken once, each visit after the first mispredicts exactly once, at the loop exit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| lk_pc | input | PC_W | PC presented by fetch |
| lk_taken | output | 1 | Predicted direction for lk_pc (1 = taken) |
| up_valid | input | 1 | A resolved branch is presented on the update port |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Actual outcome of the resolved branch (1 = taken) |

## Verification
The embedded properties assume that up_valid, up_pc and up_taken are at known levels whenever reset is released. They also assume that a lookup PC held steady over a cycle with no update to its entry expects an unchanged guess. The bench drives every input on the falling edge and holds up_valid low during reset. It builds random PCs from $urandom with a fixed seed, so aliasing PCs and unused low bits occur naturally alongside the directed cases.

// File: rtl/bht_2bit.sv
module bht_2bit #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int ENTRIES = 1 << IDX_W;
  localparam logic [1:0] CTR_INIT = 2'b01;

  logic [1:0] tbl [ENTRIES];

  wire [IDX_W-1:0] lk_idx = lk_pc[IDX_W+1:2];
  wire [IDX_W-1:0] up_idx = up_pc[IDX_W+1:2];
  wire [1:0]       up_old = tbl[up_idx];
  wire unused_pc_bits = ^{lk_pc[1:0], lk_pc[PC_W-1:IDX_W+2], up_pc[1:0], up_pc[PC_W-1:IDX_W+2]};

  logic [1:0] up_new;
  always_comb begin
    if (up_taken) up_new = (up_old == 2'b11) ? up_old : up_old + 2'd1;
    else          up_new = (up_old == 2'b00) ? up_old : up_old - 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ENTRIES; i++) tbl[i] <= CTR_INIT;
    end else if (up_valid) begin
      tbl[up_idx] <= up_new;
    end
  end

  assign lk_taken = tbl[lk_idx][1];

  logic             chk_live, chk_v, chk_t, chk_lk_taken;
  logic [IDX_W-1:0] chk_idx;
  logic [1:0]       chk_old;
  logic [PC_W-1:0]  chk_lk_pc;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chk_live <= 1'b0; chk_v <= 1'b0; chk_t <= 1'b0; chk_lk_taken <= 1'b0;
      chk_idx <= '0; chk_old <= CTR_INIT; chk_lk_pc <= '0;
    end else begin
      chk_live <= 1'b1; chk_v <= up_valid; chk_t <= up_taken; chk_lk_taken <= lk_taken;
      chk_idx <= up_idx; chk_old <= up_old; chk_lk_pc <= lk_pc;
    end
  end

  assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && chk_t && chk_old != 2'b11) |-> tbl[chk_idx] == chk_old + 2'd1);
  assert_sat_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && chk_t && chk_old == 2'b11) |-> tbl[chk_idx] == 2'b11);
  assert_step_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && !chk_t && chk_old != 2'b00) |-> tbl[chk_idx] == chk_old - 2'd1);
  assert_sat_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_v && !chk_t && chk_old == 2'b00) |-> tbl[chk_idx] == 2'b00);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_live && lk_pc == chk_lk_pc && (!chk_v || chk_idx != lk_idx)) |-> lk_taken == chk_lk_taken);
endmodule

// File: tb/tb_bht_2bit.sv
module tb_bht_2bit;
  localparam int PC_W = 32;
  localparam int IDX_W = 10;
  localparam int N = 1 << IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  wire  lk_taken;

  int total = 0, bad = 0;
  int model [N];
  bit done = 0;

  always #2 clk = ~clk;

  bht_2bit #(.PC_W(PC_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_taken(lk_taken),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  function automatic int idx_of(logic [PC_W-1:0] pc);
    return int'(pc[IDX_W+1:2]);
  endfunction

  function automatic int next_ctr(int c, bit t);
    if (t) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  task automatic check(string req, bit act, bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: lk_taken=%0b expected=%0b", req, act, exp);
    end
  endtask

  // one cycle: drive, check prediction before the edge, then apply model update
  task automatic step(string req, logic [PC_W-1:0] lpc, bit v, logic [PC_W-1:0] upc, bit t,
                      output bit pred);
    @(negedge clk);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    #1;
    pred = lk_taken;
    check(req, lk_taken, model[idx_of(lpc)] >= 2);
    @(posedge clk);
    if (v) model[idx_of(upc)] = next_ctr(model[idx_of(upc)], t);
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog: run=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    bit p;
    for (int i = 0; i < N; i++) model[i] = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: reset state everywhere sampled
    for (int i = 0; i < 8; i++) step("R1", $urandom(7 + i), 1'b0, '0, 1'b0, p);

    // R4 and R3: climb and saturate at 11
    for (int i = 0; i < 5; i++) step("R4", 32'h40, 1'b1, 32'h40, 1'b1, p);
    step("R3", 32'h40, 1'b0, '0, 1'b0, p);
    // R5: one not-taken from 11 still predicts taken, then fall and saturate at 00
    step("R5", 32'h40, 1'b1, 32'h40, 1'b0, p);
    check("R5", p, 1'b1);
    for (int i = 0; i < 5; i++) step("R5", 32'h40, 1'b1, 32'h40, 1'b0, p);
    step("R5", 32'h40, 1'b1, 32'h40, 1'b1, p);
    step("R5", 32'h40, 1'b0, '0, 1'b0, p);
    check("R5", p, 1'b0);

    // R2: alignment bits and high bits ignored (aliasing)
    step("R2", 32'h80, 1'b1, 32'h83, 1'b1, p);
    step("R2", 32'h80, 1'b1, 32'h81, 1'b1, p);
    step("R2", 32'h80 + (32'd1 << (IDX_W + 2)) + 32'd2, 1'b0, '0, 1'b0, p);
    check("R2", p, 1'b1);

    // R7: same-cycle lookup and update return the old value
    step("R7", 32'h100, 1'b1, 32'h100, 1'b1, p);
    check("R7", p, 1'b0);
    step("R7", 32'h100, 1'b1, 32'h100, 1'b0, p);
    check("R7", p, 1'b1);

    // R6: no update when up_valid is low; neighbour untouched
    step("R6", 32'h104, 1'b0, 32'h104, 1'b1, p);
    step("R6", 32'h104, 1'b1, 32'h108, 1'b1, p);
    step("R6", 32'h104, 1'b1, 32'h108, 1'b1, p);
    step("R6", 32'h104, 1'b0, '0, 1'b0, p);
    check("R6", p, 1'b0);

    // R8: loop branch, 9 taken then exit; one miss per visit after the first
    for (int v = 0; v < 5; v++) begin
      int miss = 0;
      for (int it = 0; it < 10; it++) begin
        bit outc = (it < 9);
        step("R8", 32'h200, 1'b1, 32'h200, outc, p);
        if (p != outc) miss++;
      end
      if (v > 0) begin
        total++;
        if (miss != 1) begin
          bad++;
          $display("FAIL R8: misses=%0d expected=1", miss);
        end
      end
    end

    // random mix against the model (R3 R4 R5 R6 R7)
    void'($urandom(32'd12345));
    for (int i = 0; i < 4000; i++) begin
      logic [PC_W-1:0] a = $urandom;
      logic [PC_W-1:0] b = ($urandom % 4 == 0) ? a : {$urandom} & 32'h0000_0FFF;
      step("R3", a, 1'($urandom), b, 1'($urandom), p);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule